// File: doc/BRIEF.md
# Packed Residue Arithmetic Unit

This block is a coprocessor datapath that treats one 32-bit word as five independent residues of the same integer. One residue is taken modulo 8192. The other four are taken modulo 7, 15, 31 and 127. These moduli are pairwise coprime. Each operation runs on all five channels side by side. No carry or borrow crosses from one channel into the next.

The host presents two packed operands and a 3-bit opcode with a valid/ready handshake. The packed result appears one cycle later in an output register. The result stays there until the consumer accepts it. Besides the channel-wise arithmetic, the unit can turn a plain 32-bit binary integer into its packed residues. The opposite direction, residues back to binary, is left to software.

Top module: `rns_packed_alu`

## Requirements
- R1: Field layout of a packed word: bits [31:19] hold the residue mod 8192, [18:12] mod 127, [11:7] mod 31, [6:3] mod 15, [2:0] mod 7. An all-ones field in a 2^n−1 channel is read as zero.
- R2: Opcode 3'b000 (add) gives, in every field, (A + B) mod m for that field's modulus m.
- R3: Opcode 3'b001 (subtract) gives, in every field, (A − B) mod m, with the result taken in the range 0..m−1.
- R4: Opcode 3'b010 (multiply) gives, in every field, (A × B) mod m.
- R5: Opcode 3'b011 (convert) treats in_a as an unsigned 32-bit integer X and gives the packed residues X mod m for each field. in_b has no effect.
- R6: Opcode 3'b100 (pass) returns in_a unchanged, bit for bit. in_b has no effect.
- R7: Opcodes 3'b101, 3'b110 and 3'b111 give an all-zero result.
- R8: For add, subtract, multiply and convert, no 2^n−1 field of the result is ever all ones; zero is always written as all zeros.
- R9: When in_valid and in_ready are both high at a clock edge, out_valid is high after that edge, and out_data holds the result of that request.
- R10: While out_valid is high and out_ready is low, in_ready is low, and out_data and out_valid do not change.
- R11: After a synchronous reset (rst_n low at a clock edge), out_valid is 0, out_data is 0 and in_ready is 1.
- R12: An overflow in one channel does not change any other field. Adding operands whose fields are all at their maximum gives the per-field result of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_op | input | 3 | Operation code |
| in_a | input | 32 | Packed operand A, or binary integer for convert |
| in_b | input | 32 | Packed operand B |
| out_valid | output | 1 | Result register holds an unconsumed result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Packed result |

## Verification
Every channel is combinational between the operand inputs and the output register. A wrong fold, a missed end-around carry or an unnormalised zero therefore shows in the matching bit field of out_data one cycle after the handshake, for the operands that reach that corner. A wrong field boundary shows in two adjacent fields at once, so every field is compared separately against a reference built on the % operator. Mistakes in the handshake state show at the port level. They appear as a result that changes while the consumer is stalled, or as a missing out_valid on the cycle after acceptance.

// File: rtl/rns_pkg.sv
// Package: shared constants, opcodes and field-layout helpers for the
// packed residue arithmetic unit.
// Assumes channel i of the 2^n-1 group sits above channel i-1, with the
// 2^13 channel at the top of the word.
package rns_pkg;

    localparam int WORD_W  = 32;   // packed word width
    localparam int POW2_W  = 13;   // width of the power-of-two channel
    localparam int NUM_MER = 4;    // number of 2^n-1 channels
    localparam int OP_W    = 3;    // opcode width

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_CONV = 3'd3,
        OP_PASS = 3'd4
    } rns_op_e;

    // Width n of 2^n-1 channel number idx (lowest field first).
    function automatic int mer_width(int idx);
        case (idx)
            0:       return 3;
            1:       return 4;
            2:       return 5;
            default: return 7;
        endcase
    endfunction

    // Lowest bit position of 2^n-1 channel number idx.
    function automatic int mer_lsb(int idx);
        int pos;
        pos = 0;
        for (int j = 0; j < idx; j++) pos += mer_width(j);
        return pos;
    endfunction

    // Lowest bit position of the power-of-two channel.
    localparam int POW2_LSB = mer_lsb(NUM_MER);

endpackage

// File: rtl/rns_mer_chan.sv
// Module: one residue channel modulo 2^N-1.
// Computes add, subtract, multiply, forward conversion of a binary word
// and pass-through, all combinationally. Operands may use the all-ones
// code for zero; arithmetic results are always normalised to all zeros.
// Assumes N >= 2.
module rns_mer_chan #(
    parameter int N     = 5,
    parameter int BIN_W = 32
) (
    input  logic [rns_pkg::OP_W-1:0] op,
    input  logic [N-1:0]             a,
    input  logic [N-1:0]             b,
    input  logic [BIN_W-1:0]         bin,
    output logic [N-1:0]             res
);
    import rns_pkg::*;

    localparam int CHUNKS = (BIN_W + N - 1) / N;
    localparam int PAD_W  = CHUNKS * N;
    localparam logic [N-1:0] ALL_ONES = {N{1'b1}};

    // End-around carry: fold the carry bit of an (N+1)-bit sum back in.
    function automatic logic [N-1:0] eac(logic [N:0] s);
        return s[N-1:0] + N'(s[N]);
    endfunction

    // Map the redundant all-ones zero onto all zeros.
    function automatic logic [N-1:0] norm(logic [N-1:0] v);
        return (v == ALL_ONES) ? '0 : v;
    endfunction

    logic [N-1:0]     add_r, sub_r, mul_r, conv_r;
    logic [2*N-1:0]   prod;
    logic [PAD_W-1:0] padded;

    // Modular add and subtract (subtract adds the one's complement).
    always_comb begin
        add_r = norm(eac({1'b0, a} + {1'b0, b}));
        sub_r = norm(eac({1'b0, a} + {1'b0, ~b}));
    end

    // Modular multiply: fold the high half onto the low half, then one EAC.
    always_comb begin
        prod  = (2*N)'(a) * (2*N)'(b);
        mul_r = norm(eac({1'b0, prod[N-1:0]} + {1'b0, prod[2*N-1:N]}));
    end

    // Forward conversion: sum N-bit chunks of the binary word with EAC.
    always_comb begin
        logic [N-1:0] acc;
        padded = PAD_W'(bin);
        acc    = '0;
        for (int i = 0; i < CHUNKS; i++) begin
            acc = eac({1'b0, acc} + {1'b0, padded[i*N +: N]});
        end
        conv_r = norm(acc);
    end

    // Result selection by opcode.
    always_comb begin
        case (op)
            OP_ADD:  res = add_r;
            OP_SUB:  res = sub_r;
            OP_MUL:  res = mul_r;
            OP_CONV: res = conv_r;
            OP_PASS: res = a;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/rns_pow2_chan.sv
// Module: one residue channel modulo 2^W.
// Keeps the low W bits of every sum, difference and product; forward
// conversion takes the low W bits of the binary word.
// Assumes the caller passes only the low W bits of that word.
module rns_pow2_chan #(
    parameter int W = 13
) (
    input  logic [rns_pkg::OP_W-1:0] op,
    input  logic [W-1:0]             a,
    input  logic [W-1:0]             b,
    input  logic [W-1:0]             bin_lo,
    output logic [W-1:0]             res
);
    import rns_pkg::*;

    logic [2*W-1:0] prod;

    // Full product; only its low half is kept.
    always_comb prod = (2*W)'(a) * (2*W)'(b);

    // Result selection by opcode, truncating to W bits.
    always_comb begin
        case (op)
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_MUL:  res = prod[W-1:0];
            OP_CONV: res = bin_lo;
            OP_PASS: res = a;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/rns_packed_alu.sv
// Module: packed residue arithmetic unit (top).
// Splits two packed words into five residue fields and runs one channel
// per field in parallel. The packed result is registered on an accepted
// request and held until the consumer takes it.
// Assumes the field layout given by rns_pkg.
module rns_packed_alu #(
    parameter int DATA_W = rns_pkg::WORD_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [rns_pkg::OP_W-1:0] in_op,
    input  logic [DATA_W-1:0]        in_a,
    input  logic [DATA_W-1:0]        in_b,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [DATA_W-1:0]        out_data
);
    import rns_pkg::*;

    localparam int P2_LSB = POW2_LSB;

    logic [DATA_W-1:0]  result_c;
    logic               fire;
    logic [OP_W-1:0]    op_q;

    // 2^n-1 channels, one per field.
    for (genvar g = 0; g < NUM_MER; g++) begin : g_mer
        localparam int NW  = mer_width(g);
        localparam int LSB = mer_lsb(g);

        rns_mer_chan #(
            .N     (NW),
            .BIN_W (DATA_W)
        ) u_chan (
            .op  (in_op),
            .a   (in_a[LSB +: NW]),
            .b   (in_b[LSB +: NW]),
            .bin (in_a),
            .res (result_c[LSB +: NW])
        );
    end

    // Power-of-two channel in the top field.
    rns_pow2_chan #(
        .W (POW2_W)
    ) u_pow2 (
        .op     (in_op),
        .a      (in_a[P2_LSB +: POW2_W]),
        .b      (in_b[P2_LSB +: POW2_W]),
        .bin_lo (in_a[POW2_W-1:0]),
        .res    (result_c[P2_LSB +: POW2_W])
    );

    // Accept a request when the result slot is free or being drained.
    always_comb begin
        in_ready = !out_valid || out_ready;
        fire     = in_valid && in_ready;
    end

    // Result register and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            op_q      <= '0;
        end else if (fire) begin
            out_valid <= 1'b1;
            out_data  <= result_c;
            op_q      <= in_op;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R9: an accepted request yields a valid result on the next cycle.
    a_r9_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R10: a stalled result stays put.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R11: reset empties the result slot.
    a_r11_reset: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0));

    // R7: undefined opcodes produce zero.
    a_r7_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && op_q > OP_W'(OP_PASS)) |-> (out_data == '0));

    // R8: arithmetic results never use the all-ones zero code.
    for (genvar k = 0; k < NUM_MER; k++) begin : g_norm_chk
        localparam int KW  = mer_width(k);
        localparam int KL  = mer_lsb(k);
        a_r8_norm: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && op_q <= OP_W'(OP_CONV))
                |-> (out_data[KL +: KW] != {KW{1'b1}}));
    end

endmodule

// File: tb/rns_packed_alu_tb.sv
// Bench: random and directed requests, each field checked against a
// % based reference built from the requirement field layout.
module rns_packed_alu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_op = '0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    rns_packed_alu u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_op     (in_op),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    // R1 layout: field k = 0..4 -> lsb, width, modulus.
    function automatic int f_lsb(int k);
        case (k) 0: return 0; 1: return 3; 2: return 7; 3: return 12; default: return 19; endcase
    endfunction
    function automatic int f_wid(int k);
        case (k) 0: return 3; 1: return 4; 2: return 5; 3: return 7; default: return 13; endcase
    endfunction
    function automatic longint f_mod(int k);
        return (k == 4) ? 64'd8192 : ((64'd1 << f_wid(k)) - 1);
    endfunction
    function automatic longint fld(logic [31:0] w, int k);
        return longint'((w >> f_lsb(k)) & ((32'd1 << f_wid(k)) - 1));
    endfunction

    // Reference result for one request.
    function automatic logic [31:0] ref_model(logic [2:0] op, logic [31:0] a, logic [31:0] b);
        logic [31:0] r;
        r = '0;
        for (int k = 0; k < 5; k++) begin
            longint m, fa, fb, v;
            m  = f_mod(k);
            fa = fld(a, k) % m;
            fb = fld(b, k) % m;
            case (op)
                3'd0: v = (fa + fb) % m;
                3'd1: v = (fa - fb + m) % m;
                3'd2: v = (fa * fb) % m;
                3'd3: v = longint'({32'd0, a}) % m;
                3'd4: v = fld(a, k);
                default: v = 0;
            endcase
            r = r | (32'(v) << f_lsb(k));
        end
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one request with out_ready high, check the result next cycle.
    task automatic run_op(string req, logic [2:0] op, logic [31:0] a, logic [31:0] b);
        logic [31:0] exp;
        exp = ref_model(op, a, b);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b; out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 out_valid", {31'd0, out_valid}, 32'd1);
        check(req, out_data, exp);
        if (op <= 3'd3) begin
            for (int k = 0; k < 4; k++) begin
                if (fld(out_data, k) == f_mod(k)) begin
                    total++; bad++;
                    $display("FAIL R8 field %0d actual=%h expected=not all ones", k, out_data);
                end else total++;
            end
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state.
        check("R11 out_valid", {31'd0, out_valid}, 32'd0);
        check("R11 out_data", out_data, 32'd0);
        check("R11 in_ready", {31'd0, in_ready}, 32'd1);

        // Directed corners.
        run_op("R12 max add", 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_op("R12 edge add", 3'd0, {13'd8191, 7'd126, 5'd30, 4'd14, 3'd6},
                                     {13'd1, 7'd1, 5'd1, 4'd1, 3'd1});
        run_op("R2 zero add", 3'd0, 32'd0, 32'd0);
        run_op("R3 sub wrap", 3'd1, 32'd0, {13'd1, 7'd1, 5'd1, 4'd1, 3'd1});
        run_op("R3 sub self", 3'd1, 32'h1234_5678, 32'h1234_5678);
        run_op("R4 mul max", 3'd2, {13'd8191, 7'd126, 5'd30, 4'd14, 3'd6},
                                   {13'd8191, 7'd126, 5'd30, 4'd14, 3'd6});
        run_op("R5 conv max", 3'd3, 32'hFFFF_FFFF, 32'h0);
        run_op("R5 conv b ignored", 3'd3, 32'hDEAD_BEEF, 32'hFFFF_FFFF);
        run_op("R5 conv b ignored", 3'd3, 32'hDEAD_BEEF, 32'h0000_0000);
        run_op("R6 pass", 3'd4, 32'hFFFF_FFFF, 32'h0);
        run_op("R6 pass b ignored", 3'd4, 32'hCAFE_F00D, 32'h1357_9BDF);
        run_op("R7 undef 5", 3'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_op("R7 undef 6", 3'd6, 32'h1234_5678, 32'h9ABC_DEF0);
        run_op("R7 undef 7", 3'd7, 32'h0F0F_0F0F, 32'hF0F0_F0F0);
        run_op("R1 layout single field", 3'd0, 32'h0000_1000, 32'h0000_1000);

        // R10: stall the consumer and check hold.
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_op = 3'd2; in_a = 32'h2468_ACE0; in_b = 32'h1357_9BDF;
        held = ref_model(3'd2, 32'h2468_ACE0, 32'h1357_9BDF);
        @(negedge clk);
        in_op = 3'd0; in_a = 32'h1111_1111; in_b = 32'h2222_2222;
        check("R9 stalled launch", out_data, held);
        check("R10 in_ready low", {31'd0, in_ready}, 32'd0);
        repeat (2) begin
            @(negedge clk);
            check("R10 data held", out_data, held);
            check("R10 valid held", {31'd0, out_valid}, 32'd1);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 next after drain", out_data, ref_model(3'd0, 32'h1111_1111, 32'h2222_2222));
        @(negedge clk);
        check("R10 drained", {31'd0, out_valid}, 32'd0);

        // Random requests over every opcode.
        for (int i = 0; i < 3000; i++) begin
            logic [2:0]  op;
            logic [31:0] a, b;
            op = 3'($urandom_range(0, 7));
            a  = $urandom;
            b  = $urandom;
            case (op)
                3'd0: run_op("R2 random add", op, a, b);
                3'd1: run_op("R3 random sub", op, a, b);
                3'd2: run_op("R4 random mul", op, a, b);
                3'd3: run_op("R5 random conv", op, a, b);
                3'd4: run_op("R6 random pass", op, a, b);
                default: run_op("R7 random undef", op, a, b);
            endcase
        end

        // R11: reset in the middle of a held result.
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1; in_op = 3'd4; in_a = 32'hFFFF_0000;
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R11 reset clears valid", {31'd0, out_valid}, 32'd0);
        check("R11 reset clears data", out_data, 32'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule